// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Bus Controller

This block sits between a synchronous host and an asynchronous pseudo-static RAM of 128K sixteen-bit words. A host raises a request with an address, write data, a two-bit byte mask and a write flag. The block acknowledges it with a single-cycle pulse and then runs one memory cycle on the chip-enable, write-enable, output-enable and byte-enable strobes. Each interval is a whole number of system-clock cycles, set by parameters. The defaults assume a 100 MHz clock and are rounded up. The data bus is split into an output, an output enable and an input, so that a pad ring can form the bidirectional pins.

Reads are timed from chip enable. The address and byte enables are applied one cycle before chip enable falls, and the read data is sampled when chip enable rises again. Writes hold output enable high, drive data from the cycle in which write enable falls, and end with write enable and chip enable rising together. After every access the chip is deselected for a fixed recovery interval. This gives the memory time to release the data bus before the controller can drive it again.

The memory needs a full deselected read-cycle time now and then to refresh itself. A watchdog counts the cycles since the last deselect that was long enough. When that count reaches its limit, the watchdog holds off new accesses until chip enable has stayed high long enough.

Top module: `psram_bus_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is 2'b11, `mem_dq_oe` is 0, and `host_ack` and `host_rvalid` are 0.
- R2: A request is accepted only while the controller is idle. Acceptance shows as a `host_ack` pulse exactly one cycle wide. The address is applied one cycle before `mem_ce_n` falls and stays unchanged while `mem_ce_n` is low.
- R3: For a read (`host_wr`=0), `mem_ce_n` and `mem_oe_n` are low and `mem_we_n` is high for exactly RD_CYC cycles. The sampled word appears on `host_rdata` with `host_rvalid` high for one cycle, RD_CYC+1 cycles after the cycle in which `host_ack` is high.
- R4: For a write (`host_wr`=1), `mem_ce_n` and `mem_we_n` are low for exactly WR_CYC cycles while `mem_oe_n` stays high. `mem_dq_oe` is high the whole time `mem_we_n` is low, so the word is stored when both strobes rise.
- R5: Host mask bit 0 drives `mem_be_n[0]` low and selects data bits 7:0. Mask bit 1 drives `mem_be_n[1]` low and selects bits 15:8. A write changes only the selected bytes in memory.
- R6: On a read, a byte lane that the mask does not select returns zero on `host_rdata`, whatever the memory presents on it.
- R7: The controller never drives `mem_dq_oe` while `mem_oe_n` is low, and keeps the bus released for at least TURN_CYC cycles after `mem_oe_n` rises. Between two accesses `mem_ce_n` stays high for at least TURN_CYC+2 cycles.
- R8: A run of at least RC_CYC consecutive cycles with `mem_ce_n` high clears the watchdog. Once WDOG_LIMIT cycles have passed without such a run, no new request is accepted until one has happened.

Default timing parameters, in cycles: RD_CYC is 6, WR_CYC is 5, TURN_CYC is 3, RC_CYC is 6 and WDOG_LIMIT is 1500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_bmask | input | 2 | Byte select, bit 0 = low byte |
| host_ack | output | 1 | One-cycle acceptance pulse |
| host_rvalid | output | 1 | Read data valid, one cycle |
| host_rdata | output | 16 | Read data, unselected bytes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, bit 0 = bits 7:0 |
| mem_dq_out | output | 16 | Data to the bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from the bus |

## Verification
Every result of this block is tied to a known number of cycles after a stimulus. Read data is due exactly RD_CYC+1 cycles after the acknowledge. Chip-enable-low spans last RD_CYC cycles for a read and WR_CYC cycles for a write. Deselect gaps last at least TURN_CYC+2 cycles, and a watchdog deselect lasts at least RC_CYC cycles. The bench records the cycle number of each acknowledge next to the expected word, and compares the latency of each arriving result with that fixed figure. Its memory model returns junk until RD_CYC cycles of chip enable have passed, so an early sample fails the data comparison. Span lengths are measured on the pins between edges, in the middle of each clock period.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_RECOV  = 2'd3
    } ctl_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_lane_sel.sv
module psram_lane_sel #(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic [LANES-1:0]  lane_on,
    output logic [DATA_W-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*8 +: 8] = lane_on[g] ? din[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/psram_wdog.sv
module psram_wdog #(
    parameter int RC_CYC     = 6,
    parameter int WDOG_LIMIT = 1500,
    localparam int HI_W  = $clog2(RC_CYC + 1),
    localparam int SEL_W = $clog2(WDOG_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic block
);
    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [SEL_W-1:0] sel;
    } wd_t;

    wd_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (ce_n) begin
            w_d.hi = (w_q.hi == HI_W'(RC_CYC)) ? w_q.hi : w_q.hi + 1'b1;
        end else begin
            w_d.hi = '0;
        end
        if (ce_n && (w_q.hi >= HI_W'(RC_CYC - 1))) begin
            w_d.sel = '0;
        end else if (w_q.sel != SEL_W'(WDOG_LIMIT)) begin
            w_d.sel = w_q.sel + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.hi  <= HI_W'(RC_CYC);
            w_q.sel <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign block = (w_q.sel >= SEL_W'(WDOG_LIMIT));

    // R8
    wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_n) && ce_n && $past(w_q.hi) >= HI_W'(RC_CYC - 1)) |-> !block);
endmodule

// File: rtl/psram_bus_ctrl.sv
module psram_bus_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 16,
    parameter int RD_CYC     = 6,
    parameter int WR_CYC     = 5,
    parameter int TURN_CYC   = 3,
    parameter int RC_CYC     = 6,
    parameter int WDOG_LIMIT = 1500,
    localparam int LANES     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_bmask,
    output logic              host_ack,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_T = max_of(max_of(RD_CYC, WR_CYC), TURN_CYC);
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam int OEC_W = $clog2(TURN_CYC + 3);

    typedef struct packed {
        ctl_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic [LANES-1:0]  be_n;
        logic [DATA_W-1:0] dout;
        logic              dq_oe;
        logic              ack;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t r_d, r_q;
    logic              wd_block;
    logic [DATA_W-1:0] lane_data;
    logic              span_done;

    psram_wdog #(.RC_CYC(RC_CYC), .WDOG_LIMIT(WDOG_LIMIT)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (r_q.ce_n),
        .block (wd_block)
    );

    psram_lane_sel #(.DATA_W(DATA_W)) u_lanes (
        .din     (mem_dq_in),
        .lane_on (~r_q.be_n),
        .dout    (lane_data)
    );

    assign span_done = r_q.wr ? (r_q.cnt == CNT_W'(WR_CYC - 1))
                              : (r_q.cnt == CNT_W'(RD_CYC - 1));

    always_comb begin
        r_d        = r_q;
        r_d.ack    = 1'b0;
        r_d.rvalid = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (host_req && !wd_block) begin
                    r_d.ack  = 1'b1;
                    r_d.wr   = host_wr;
                    r_d.addr = host_addr;
                    r_d.be_n = ~host_bmask;
                    r_d.dout = host_wdata;
                    r_d.st   = ST_SETUP;
                end
            end
            ST_SETUP: begin
                r_d.ce_n = 1'b0;
                r_d.cnt  = '0;
                r_d.st   = ST_ACCESS;
                if (r_q.wr) begin
                    r_d.we_n  = 1'b0;
                    r_d.dq_oe = 1'b1;
                end else begin
                    r_d.oe_n = 1'b0;
                end
            end
            ST_ACCESS: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (span_done) begin
                    r_d.ce_n = 1'b1;
                    r_d.we_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.cnt  = '0;
                    r_d.st   = ST_RECOV;
                    if (!r_q.wr) begin
                        r_d.rvalid = 1'b1;
                        r_d.rdata  = lane_data;
                    end
                end
            end
            ST_RECOV: begin
                r_d.dq_oe = 1'b0;
                r_d.be_n  = '1;
                r_d.cnt   = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(TURN_CYC - 1)) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.ce_n   <= 1'b1;
            r_q.we_n   <= 1'b1;
            r_q.oe_n   <= 1'b1;
            r_q.be_n   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_ack    = r_q.ack;
    assign host_rvalid = r_q.rvalid;
    assign host_rdata  = r_q.rdata;
    assign mem_addr    = r_q.addr;
    assign mem_ce_n    = r_q.ce_n;
    assign mem_we_n    = r_q.we_n;
    assign mem_oe_n    = r_q.oe_n;
    assign mem_be_n    = r_q.be_n;
    assign mem_dq_out  = r_q.dout;
    assign mem_dq_oe   = r_q.dq_oe;

    // Cycles that output enable has been high, for the bus turnaround check.
    logic [OEC_W-1:0] oe_hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_hi_q <= OEC_W'(TURN_CYC + 2);
        end else if (!r_q.oe_n) begin
            oe_hi_q <= '0;
        end else if (oe_hi_q != OEC_W'(TURN_CYC + 2)) begin
            oe_hi_q <= oe_hi_q + 1'b1;
        end
    end

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
    // R3
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> ($past(!mem_ce_n) && $past(!mem_oe_n) && $past(mem_we_n) && mem_ce_n));
    // R4
    we_low_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));
    // R7
    bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && !$past(mem_dq_oe)) |-> (mem_oe_n && oe_hi_q >= OEC_W'(TURN_CYC)));
    // R8
    wd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> !$past(wd_block));
endmodule

// File: tb/psram_bus_ctrl_test.sv
module psram_bus_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int RD   = 6;
    localparam int WR   = 5;
    localparam int TURN = 3;
    localparam int RC   = 6;
    localparam int LIM  = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 1'b0, host_wr = 1'b0;
    logic [16:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_bmask = '0;
    logic host_ack, host_rvalid;
    logic [15:0] host_rdata;
    logic [16:0] mem_addr;
    logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out, mem_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_bus_ctrl #(.RD_CYC(RD), .WR_CYC(WR), .TURN_CYC(TURN),
                     .RC_CYC(RC), .WDOG_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_bmask(host_bmask),
        .host_ack(host_ack), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model
    logic [15:0] dev_mem [0:(1<<17)-1];
    int dev_cnt = 0;
    always @(posedge clk) dev_cnt <= mem_ce_n ? 0 : dev_cnt + 1;
    always_comb begin
        mem_dq_in = 16'hDEAD;
        if (!mem_ce_n && !mem_oe_n && mem_we_n && dev_cnt >= RD - 1)
            mem_dq_in = {mem_be_n[1] ? 8'hEE : dev_mem[mem_addr][15:8],
                         mem_be_n[0] ? 8'hEE : dev_mem[mem_addr][7:0]};
    end
    logic [16:0] cap_a; logic [15:0] cap_d; logic [1:0] cap_be; bit cap_p = 0;
    int bus_viol = 0;
    always @(negedge clk) if (rst_n) begin
        if (!mem_ce_n && !mem_we_n) begin
            cap_a = mem_addr; cap_d = mem_dq_out; cap_be = mem_be_n; cap_p = 1;
            if (!mem_dq_oe) bus_viol++;
        end else if (cap_p) begin
            if (!cap_be[0]) dev_mem[cap_a][7:0]  = cap_d[7:0];
            if (!cap_be[1]) dev_mem[cap_a][15:8] = cap_d[15:8];
            cap_p = 0;
        end
        if (mem_dq_oe && !mem_oe_n) bus_viol++;
    end

    // Pin monitor
    int hi_run = 100, lo_run = 0, since = 0, long_runs = 0;
    bit saw_we = 0, prev_ce = 1, burst = 0;
    always @(negedge clk) if (rst_n) begin
        if (mem_ce_n) begin
            if (!prev_ce) begin
                if (saw_we) chk(lo_run == WR, "R4 ce low span", lo_run, WR);
                else        chk(lo_run == RD, "R3 ce low span", lo_run, RD);
            end
            hi_run++; lo_run = 0; saw_we = 0;
            if (hi_run >= RC) since = 0; else since++;
            if (hi_run == RC && burst) long_runs++;
        end else begin
            if (prev_ce) begin
                chk(hi_run >= TURN + 2, "R7 ce high gap", hi_run, TURN + 2);
                chk(since <= LIM + 16, "R8 selected span", since, LIM + 16);
            end
            lo_run++; hi_run = 0; since++;
            if (!mem_we_n) saw_we = 1;
        end
        prev_ce = mem_ce_n;
    end

    // Scoreboard
    logic [15:0] exp_q[$];
    int ack_q[$];
    string tag_q[$];
    logic [15:0] shadow [0:(1<<17)-1];
    always @(negedge clk) if (rst_n && host_rvalid) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected rvalid", host_rdata, 0);
        else begin
            automatic logic [15:0] e = exp_q.pop_front();
            automatic int a = ack_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(host_rdata == e, t, host_rdata, e);
            chk(cyc - a == RD + 1, "R3 read latency", cyc - a, RD + 1);
        end
    end

    task automatic drive(input bit wr, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] m, input string tag);
        @(negedge clk);
        host_req = 1; host_wr = wr; host_addr = a; host_wdata = d; host_bmask = m;
        do @(negedge clk); while (!host_ack);
        host_req = 0;
        if (wr) begin
            if (m[0]) shadow[a][7:0]  = d[7:0];
            if (m[1]) shadow[a][15:8] = d[15:8];
        end else begin
            exp_q.push_back({m[1] ? shadow[a][15:8] : 8'h00, m[0] ? shadow[a][7:0] : 8'h00});
            ack_q.push_back(cyc);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        chk(!host_ack, "R2 ack one cycle", host_ack, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog timeout actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(mem_be_n == 2'b11, "R1 byte enables", mem_be_n, 2'b11);
        chk(!mem_dq_oe && !host_ack && !host_rvalid, "R1 bus released", {mem_dq_oe, host_ack, host_rvalid}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(mem_ce_n && !mem_dq_oe, "R1 after reset", {mem_ce_n, mem_dq_oe}, 2'b10);

        drive(1, 17'h00010, 16'h1234, 2'b11, "R4");
        drive(1, 17'h1FFFF, 16'hABCD, 2'b11, "R4");
        drive(1, 17'h0AA55, 16'h5A5A, 2'b11, "R4");
        drive(0, 17'h00010, 16'h0, 2'b11, "R3 read word A");
        drive(0, 17'h1FFFF, 16'h0, 2'b11, "R2 read top address");
        drive(0, 17'h0AA55, 16'h0, 2'b11, "R3 read word C");
        // R5 partial writes
        drive(1, 17'h00010, 16'hFF77, 2'b01, "R5");
        drive(1, 17'h1FFFF, 16'h99EE, 2'b10, "R5");
        drive(0, 17'h00010, 16'h0, 2'b11, "R5 low byte write");
        drive(0, 17'h1FFFF, 16'h0, 2'b11, "R5 high byte write");
        // R6 masked reads
        drive(0, 17'h0AA55, 16'h0, 2'b01, "R6 low lane read");
        drive(0, 17'h0AA55, 16'h0, 2'b10, "R6 high lane read");
        // R8 back-to-back reads
        burst = 1;
        for (int i = 0; i < 30; i++) drive(0, 17'h0AA55, 16'h0, 2'b11, "R8 burst read");
        repeat (20) @(negedge clk);
        burst = 0;
        chk(long_runs >= 1, "R8 forced deselect", long_runs, 1);
        chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
        chk(bus_viol == 0, "R7 bus drive rules", bus_viol, 0);
        finish_run();
    end
endmodule